// File: doc/BRIEF.md
# Serial Flash Parameter Discovery Sequencer

This block brings up a serial NOR flash after reset. On a `start` pulse it asks a separate command engine for a fixed series of flash transactions. It reads the identity bytes first. If the part needs it, it sends a write-enable and a global-unprotect command. It then polls the status register until the part is idle. Next it reads the discoverable-parameter header and, through the pointer held in that header, the basic parameter table. Each stage passes or fails in hardware. The result is a one-cycle `done` with an `error` flag and the capacity of the device in bytes.

The command engine handles the bit-level serial traffic. The sequencer presents a request as opcode, address byte count, address word and expected return byte count, and holds `cmdReq` high. The engine returns each received byte with `rspValid` and ends the transaction with a one-cycle `cmdDone`. A new request may follow at once, without `cmdReq` dropping, when the next step is another transaction.

Top module: `flash_param_probe`

## Requirements
- R1: After `start`, the first request is opcode 0x9F with 0 address bytes and 3 return bytes.
- R2: When the first identity byte is 0xBF, the next two requests are 0x06 and then 0x98, each with 0 address and 0 return bytes. For any other identity byte the sequence goes straight to status polling.
- R3: Status polling uses opcode 0x05 with 1 return byte and repeats while bit 0 of the returned byte is 1. Other bits are ignored. If POLL_LIMIT polls in a row all report busy, the run ends with `error`=1.
- R4: Once the status reads idle, the header is read with opcode 0x5A, 4 address bytes, address word 0 and 16 return bytes.
- R5: The run fails unless header bytes 0..3 are 0x53,0x46,0x44,0x50 and header byte 5 is 0x01.
- R6: The run fails unless header byte 8 is 0x00 and header byte 10 is 0x01.
- R7: The table is read with opcode 0x5A, 4 address bytes, address word {hdr[14],hdr[13],hdr[12],8'h00} and 8 return bytes. No table read is issued when the header check fails.
- R8: The run fails unless table byte 0 bits [1:0] are 2'b01, table byte 1 is 0x20, table byte 2 bit 2 is 0 and table byte 7 bit 7 is 0.
- R9: On success, `sizeBytes` equals D/8+1, where D={tbl[7],tbl[6],tbl[5],tbl[4]}. On failure `sizeBytes` is 0.
- R10: `done` is a one-cycle pulse and `cmdReq` is low in that cycle. `error` and `sizeBytes` change only together with `done`. `start` has no effect while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a discovery run (ignored while busy) |
| cmdReq | output | 1 | Transaction request, held until `cmdDone` |
| cmdOpcode | output | 8 | Opcode of the requested transaction |
| cmdAddrBytes | output | 3 | Number of address bytes to send (0 or 4) |
| cmdAddr | output | 32 | Address word, most significant byte sent first |
| cmdRetBytes | output | 5 | Number of bytes the engine must return |
| rspValid | input | 1 | One returned byte is valid on `rspData` |
| rspData | input | 8 | Returned byte |
| cmdDone | input | 1 | Transaction finished (one-cycle pulse) |
| done | output | 1 | Run finished (one-cycle pulse) |
| error | output | 1 | Result of the last run, 1 = failed |
| sizeBytes | output | 32 | Capacity in bytes from the last run |

## Verification
The assertions assume the command engine obeys the handshake. It raises `cmdDone` only while `cmdReq` is high, at least one cycle after the last `rspValid` of that transaction, and it returns exactly `cmdRetBytes` bytes. The bench flash model keeps to this. It delivers the bytes on separate falling edges, leaves an idle cycle before the single-cycle `cmdDone`, and re-reads the request fields before each new transaction. Header and table faults are injected one byte at a time, so each check stage is reached in isolation.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam logic [7:0] OP_IDENT  = 8'h9F;
  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_UNPROT = 8'h98;
  localparam logic [7:0] OP_STATUS = 8'h05;
  localparam logic [7:0] OP_PARAM  = 8'h5A;
  localparam logic [7:0] VENDOR_LOCKED = 8'hBF;

  localparam int HDR_BYTES = 16;
  localparam int TBL_BYTES = 8;
  localparam int IDX_W     = $clog2(HDR_BYTES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_IDENT, S_WREN, S_UNPROT, S_POLL, S_HDR, S_TBL
  } probe_state_e;

  typedef enum logic [1:0] {
    TGT_ID, TGT_STAT, TGT_HDR, TGT_TBL
  } cap_tgt_e;

  typedef struct packed {
    logic     clrIdx;
    logic     capEn;
    cap_tgt_e capTgt;
    logic     loadSize;
    logic     clrSize;
  } probe_strb_t;

endpackage

// File: rtl/flash_probe_dp.sv
module flash_probe_dp
  import flash_probe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  probe_strb_t strb,
  input  logic        rspValid,
  input  logic [7:0]  rspData,
  output logic        idLocked,
  output logic        statBusy,
  output logic        hdrOk,
  output logic        tblOk,
  output logic [31:0] tblPtr,
  output logic [31:0] sizeBytes
);

  logic [IDX_W-1:0] byteIdx;
  logic [7:0]       idFirst;
  logic [7:0]       statByte;
  logic [7:0]       hdrMem [HDR_BYTES];
  logic [7:0]       tblMem [TBL_BYTES];
  logic [31:0]      density;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byteIdx  <= '0;
      idFirst  <= '0;
      statByte <= '0;
      for (int i = 0; i < HDR_BYTES; i++) hdrMem[i] <= '0;
      for (int i = 0; i < TBL_BYTES; i++) tblMem[i] <= '0;
    end else if (strb.clrIdx) begin
      byteIdx <= '0;
    end else if (strb.capEn && rspValid) begin
      byteIdx <= byteIdx + 1'b1;
      unique case (strb.capTgt)
        TGT_ID:   if (byteIdx == '0) idFirst <= rspData;
        TGT_STAT: statByte <= rspData;
        TGT_HDR:  if (byteIdx < IDX_W'(HDR_BYTES)) hdrMem[byteIdx[3:0]] <= rspData;
        TGT_TBL:  if (byteIdx < IDX_W'(TBL_BYTES)) tblMem[byteIdx[2:0]] <= rspData;
        default:  ;
      endcase
    end
  end

  assign idLocked = (idFirst == VENDOR_LOCKED);
  assign statBusy = statByte[0];

  assign hdrOk = (hdrMem[0] == 8'h53) && (hdrMem[1] == 8'h46) &&
                 (hdrMem[2] == 8'h44) && (hdrMem[3] == 8'h50) &&
                 (hdrMem[5] == 8'h01) && (hdrMem[8] == 8'h00) &&
                 (hdrMem[10] == 8'h01);

  assign tblPtr = {hdrMem[14], hdrMem[13], hdrMem[12], 8'h00};

  assign tblOk = (tblMem[0][1:0] == 2'b01) && (tblMem[1] == 8'h20) &&
                 !tblMem[2][2] && !tblMem[7][7];

  assign density = {tblMem[7], tblMem[6], tblMem[5], tblMem[4]};

  always_ff @(posedge clk) begin
    if (!rst_n)             sizeBytes <= '0;
    else if (strb.loadSize) sizeBytes <= (density >> 3) + 32'd1;
    else if (strb.clrSize)  sizeBytes <= '0;
  end

endmodule

// File: rtl/flash_probe_ctl.sv
module flash_probe_ctl
  import flash_probe_pkg::*;
#(
  parameter int POLL_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cmdDone,
  input  logic        idLocked,
  input  logic        statBusy,
  input  logic        hdrOk,
  input  logic        tblOk,
  input  logic [31:0] tblPtr,
  output logic        cmdReq,
  output logic [7:0]  cmdOpcode,
  output logic [2:0]  cmdAddrBytes,
  output logic [31:0] cmdAddr,
  output logic [4:0]  cmdRetBytes,
  output probe_strb_t strb,
  output logic        done,
  output logic        error
);

  localparam int PCNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [PCNT_W-1:0] POLL_LAST = PCNT_W'(POLL_LIMIT - 1);

  probe_state_e state;
  logic [PCNT_W-1:0] pollCnt;
  logic finOk, finErr;

  always_comb begin
    cmdReq       = (state != S_IDLE);
    cmdOpcode    = 8'h00;
    cmdAddrBytes = 3'd0;
    cmdAddr      = 32'd0;
    cmdRetBytes  = 5'd0;
    unique case (state)
      S_IDENT:  begin cmdOpcode = OP_IDENT;  cmdRetBytes = 5'd3; end
      S_WREN:   cmdOpcode = OP_WREN;
      S_UNPROT: cmdOpcode = OP_UNPROT;
      S_POLL:   begin cmdOpcode = OP_STATUS; cmdRetBytes = 5'd1; end
      S_HDR:    begin cmdOpcode = OP_PARAM; cmdAddrBytes = 3'd4;
                      cmdRetBytes = 5'(HDR_BYTES); end
      S_TBL:    begin cmdOpcode = OP_PARAM; cmdAddrBytes = 3'd4;
                      cmdAddr = tblPtr; cmdRetBytes = 5'(TBL_BYTES); end
      default:  ;
    endcase
  end

  always_comb begin
    finOk  = (state == S_TBL) && cmdDone && tblOk;
    finErr = cmdDone && (((state == S_TBL) && !tblOk) ||
                         ((state == S_HDR) && !hdrOk) ||
                         ((state == S_POLL) && statBusy && (pollCnt == POLL_LAST)));
  end

  always_comb begin
    strb.clrIdx   = cmdDone || ((state == S_IDLE) && start);
    strb.capEn    = (state == S_IDENT) || (state == S_POLL) ||
                    (state == S_HDR) || (state == S_TBL);
    unique case (state)
      S_POLL:  strb.capTgt = TGT_STAT;
      S_HDR:   strb.capTgt = TGT_HDR;
      S_TBL:   strb.capTgt = TGT_TBL;
      default: strb.capTgt = TGT_ID;
    endcase
    strb.loadSize = finOk;
    strb.clrSize  = finErr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      pollCnt <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (finOk || finErr) begin
        state <= S_IDLE;
        done  <= 1'b1;
        error <= finErr;
      end else begin
        unique case (state)
          S_IDLE:   if (start) state <= S_IDENT;
          S_IDENT:  if (cmdDone) begin
                      state   <= idLocked ? S_WREN : S_POLL;
                      pollCnt <= '0;
                    end
          S_WREN:   if (cmdDone) state <= S_UNPROT;
          S_UNPROT: if (cmdDone) state <= S_POLL;
          S_POLL:   if (cmdDone) begin
                      if (statBusy) pollCnt <= pollCnt + 1'b1;
                      else          state   <= S_HDR;
                    end
          S_HDR:    if (cmdDone) state <= S_TBL;
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/flash_param_probe.sv
module flash_param_probe
  import flash_probe_pkg::*;
#(
  parameter int POLL_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        cmdReq,
  output logic [7:0]  cmdOpcode,
  output logic [2:0]  cmdAddrBytes,
  output logic [31:0] cmdAddr,
  output logic [4:0]  cmdRetBytes,
  input  logic        rspValid,
  input  logic [7:0]  rspData,
  input  logic        cmdDone,
  output logic        done,
  output logic        error,
  output logic [31:0] sizeBytes
);

  probe_strb_t strb;
  logic idLocked, statBusy, hdrOk, tblOk;
  logic [31:0] tblPtr;

  flash_probe_ctl #(.POLL_LIMIT(POLL_LIMIT)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmdDone(cmdDone),
    .idLocked(idLocked), .statBusy(statBusy), .hdrOk(hdrOk), .tblOk(tblOk),
    .tblPtr(tblPtr), .cmdReq(cmdReq), .cmdOpcode(cmdOpcode),
    .cmdAddrBytes(cmdAddrBytes), .cmdAddr(cmdAddr), .cmdRetBytes(cmdRetBytes),
    .strb(strb), .done(done), .error(error)
  );

  flash_probe_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .rspValid(rspValid),
    .rspData(rspData), .idLocked(idLocked), .statBusy(statBusy),
    .hdrOk(hdrOk), .tblOk(tblOk), .tblPtr(tblPtr), .sizeBytes(sizeBytes)
  );

endmodule

// File: rtl/flash_param_probe_chk.sv
module flash_param_probe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmdReq,
  input logic        cmdDone,
  input logic [7:0]  cmdOpcode,
  input logic        done,
  input logic        error,
  input logic [31:0] sizeBytes
);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmdReq);

  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReq && !cmdDone) |=> (cmdReq && $stable(cmdOpcode)));

  a_r10_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(sizeBytes));

  a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(error));

  a_r9_size_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !error) |-> (sizeBytes != 32'd0));

  a_r9_size_zero_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    (done && error) |-> (sizeBytes == 32'd0));

endmodule

bind flash_param_probe flash_param_probe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmdReq(cmdReq), .cmdDone(cmdDone),
  .cmdOpcode(cmdOpcode), .done(done), .error(error), .sizeBytes(sizeBytes)
);

// File: tb/flash_param_probe_tb.sv
module flash_param_probe_tb;

  localparam int LIMIT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rspValid = 1'b0;
  logic [7:0] rspData = 8'h00;
  logic cmdDone = 1'b0;
  logic cmdReq, done, error;
  logic [7:0] cmdOpcode;
  logic [2:0] cmdAddrBytes;
  logic [31:0] cmdAddr, sizeBytes;
  logic [4:0] cmdRetBytes;

  always #2 clk = ~clk;

  flash_param_probe #(.POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cmdReq(cmdReq),
    .cmdOpcode(cmdOpcode), .cmdAddrBytes(cmdAddrBytes), .cmdAddr(cmdAddr),
    .cmdRetBytes(cmdRetBytes), .rspValid(rspValid), .rspData(rspData),
    .cmdDone(cmdDone), .done(done), .error(error), .sizeBytes(sizeBytes)
  );

  typedef struct packed {
    logic [7:0]  id0;
    logic [7:0]  busy;
    logic [4:0]  hIdx;
    logic [7:0]  hMask;
    logic [2:0]  tIdx;
    logic [7:0]  tMask;
    logic [31:0] dens;
    logic        expErr;
    logic [31:0] expSize;
    logic [7:0]  expCmds;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'hC2, 8'd0,  5'd0,  8'h00, 3'd0, 8'h00, 32'h00FFFFFF, 1'b0, 32'h00200000, 8'd4},
    '{8'hBF, 8'd2,  5'd0,  8'h00, 3'd0, 8'h00, 32'h03FFFFFF, 1'b0, 32'h00800000, 8'd8},
    '{8'hEF, 8'd0,  5'd0,  8'h01, 3'd0, 8'h00, 32'h00FFFFFF, 1'b1, 32'h0,        8'd3},
    '{8'hEF, 8'd0,  5'd5,  8'h03, 3'd0, 8'h00, 32'h00FFFFFF, 1'b1, 32'h0,        8'd3},
    '{8'hEF, 8'd0,  5'd8,  8'h01, 3'd0, 8'h00, 32'h00FFFFFF, 1'b1, 32'h0,        8'd3},
    '{8'hEF, 8'd0,  5'd10, 8'h01, 3'd0, 8'h00, 32'h00FFFFFF, 1'b1, 32'h0,        8'd3},
    '{8'hEF, 8'd0,  5'd0,  8'h00, 3'd0, 8'h01, 32'h00FFFFFF, 1'b1, 32'h0,        8'd4},
    '{8'hEF, 8'd0,  5'd0,  8'h00, 3'd1, 8'h01, 32'h00FFFFFF, 1'b1, 32'h0,        8'd4},
    '{8'hEF, 8'd0,  5'd0,  8'h00, 3'd2, 8'h04, 32'h00FFFFFF, 1'b1, 32'h0,        8'd4},
    '{8'hEF, 8'd0,  5'd0,  8'h00, 3'd7, 8'h80, 32'h7FFFFFFF, 1'b1, 32'h0,        8'd4},
    '{8'hEF, 8'd0,  5'd0,  8'h00, 3'd0, 8'h00, 32'h7FFFFFFF, 1'b0, 32'h10000000, 8'd4},
    '{8'hEF, 8'd0,  5'd0,  8'h00, 3'd0, 8'h00, 32'h00000007, 1'b0, 32'h00000001, 8'd4},
    '{8'hEF, 8'd16, 5'd0,  8'h00, 3'd0, 8'h00, 32'h00FFFFFF, 1'b1, 32'h0,        8'd17},
    '{8'hEF, 8'd15, 5'd0,  8'h00, 3'd0, 8'h00, 32'h00FFFFFF, 1'b0, 32'h00200000, 8'd19}
  };

  int nTests = 0;
  int nFail = 0;
  bit finished = 1'b0;

  vec_t cur;
  int busyLeft;
  int logCnt;
  logic [7:0]  logOp   [64];
  logic [2:0]  logAb   [64];
  logic [31:0] logAddr [64];
  logic [4:0]  logRet  [64];

  function automatic logic [7:0] hdrByte(input int i);
    logic [7:0] b;
    case (i)
      0: b = 8'h53;  1: b = 8'h46;  2: b = 8'h44;  3: b = 8'h50;
      4: b = 8'h06;  5: b = 8'h01;  6: b = 8'h00;  7: b = 8'hFF;
      8: b = 8'h00;  9: b = 8'h06; 10: b = 8'h01; 11: b = 8'h09;
      12: b = 8'h30; 13: b = 8'h00; 14: b = 8'h00; default: b = 8'hFF;
    endcase
    if (i == int'(cur.hIdx)) b = b ^ cur.hMask;
    return b;
  endfunction

  function automatic logic [7:0] tblByte(input int i);
    logic [7:0] b;
    case (i)
      0: b = 8'hE5; 1: b = 8'h20; 2: b = 8'hF1; 3: b = 8'hFF;
      4: b = cur.dens[7:0];   5: b = cur.dens[15:8];
      6: b = cur.dens[23:16]; default: b = cur.dens[31:24];
    endcase
    if (i == int'(cur.tIdx)) b = b ^ cur.tMask;
    return b;
  endfunction

  // Flash and command-engine model
  initial begin
    forever begin
      @(negedge clk);
      if (cmdReq && rst_n) begin
        automatic logic [7:0] op = cmdOpcode;
        automatic logic [31:0] ad = cmdAddr;
        automatic int nr = int'(cmdRetBytes);
        if (logCnt < 64) begin
          logOp[logCnt] = op; logAb[logCnt] = cmdAddrBytes;
          logAddr[logCnt] = ad; logRet[logCnt] = cmdRetBytes;
        end
        logCnt++;
        for (int i = 0; i < nr; i++) begin
          rspValid = 1'b1;
          if (op == 8'h9F) rspData = (i == 0) ? cur.id0 : 8'h20 + 8'(i);
          else if (op == 8'h05) begin
            if (busyLeft > 0) begin rspData = 8'h03; busyLeft--; end
            else rspData = 8'h02;
          end
          else if (ad == 32'd0) rspData = hdrByte(i);
          else rspData = tblByte(i);
          @(negedge clk);
          rspValid = 1'b0;
          @(negedge clk);
        end
        cmdDone = 1'b1;
        @(negedge clk);
        cmdDone = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int doneSeen;
  logic errAtDone;
  logic [31:0] sizeAtDone;

  task automatic runOne(input vec_t v, input bit extraStart);
    cur = v;
    busyLeft = int'(v.busy);
    logCnt = 0;
    doneSeen = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      if (extraStart && c == 20) start = 1'b1;
      if (extraStart && c == 21) start = 1'b0;
      if (done) begin
        doneSeen++;
        errAtDone = error;
        sizeAtDone = sizeBytes;
        @(negedge clk);
        if (done) doneSeen++;
        break;
      end
    end
    for (int c = 0; c < 60; c++) @(negedge clk);
  endtask

  initial begin
    for (int c = 0; c < 150000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    cur = VECS[0];
    busyLeft = 0;
    logCnt = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check(!done && !error && !cmdReq && sizeBytes == 0, "R10", "reset outputs",
          {28'd0, done, error, cmdReq, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!cmdReq, "R10", "no request without start", {31'd0, cmdReq}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      runOne(VECS[k], 1'b0);
      check(doneSeen == 1, "R10", $sformatf("vec %0d done pulse count", k),
            doneSeen, 1);
      check(errAtDone == VECS[k].expErr, VECS[k].expErr ? "R5/R6/R8/R3" : "R9",
            $sformatf("vec %0d error", k), {31'd0, errAtDone}, {31'd0, VECS[k].expErr});
      check(sizeAtDone == VECS[k].expSize, "R9", $sformatf("vec %0d size", k),
            sizeAtDone, VECS[k].expSize);
      check(logCnt == int'(VECS[k].expCmds), "R7", $sformatf("vec %0d command count", k),
            logCnt, {24'd0, VECS[k].expCmds});
    end

    // Directed: command fields of a plain run
    runOne(VECS[0], 1'b0);
    check(logOp[0] == 8'h9F && logAb[0] == 0 && logRet[0] == 3, "R1", "identity request",
          {logOp[0], 8'(logAb[0]), 8'(logRet[0]), 8'd0}, 32'h9F000300);
    check(logOp[1] == 8'h05 && logRet[1] == 1 && logAb[1] == 0, "R2", "no unlock for other id",
          {24'd0, logOp[1]}, 32'h05);
    check(logOp[2] == 8'h5A && logAb[2] == 4 && logAddr[2] == 0 && logRet[2] == 16,
          "R4", "header request", logAddr[2], 32'd0);
    check(logOp[3] == 8'h5A && logAb[3] == 4 && logAddr[3] == 32'h00003000 && logRet[3] == 8,
          "R7", "table request", logAddr[3], 32'h00003000);

    // Directed: locked vendor id sequence
    runOne(VECS[1], 1'b0);
    check(logOp[1] == 8'h06 && logRet[1] == 0 && logAb[1] == 0, "R2", "write enable first",
          {24'd0, logOp[1]}, 32'h06);
    check(logOp[2] == 8'h98 && logRet[2] == 0 && logAb[2] == 0, "R2", "unprotect second",
          {24'd0, logOp[2]}, 32'h98);
    check(logOp[3] == 8'h05 && logOp[5] == 8'h05 && logOp[6] == 8'h5A, "R3", "polls until idle",
          {24'd0, logOp[6]}, 32'h5A);

    // Directed: start while busy is ignored
    runOne(VECS[0], 1'b1);
    check(doneSeen == 1 && logCnt == 4, "R10", "start ignored while busy",
          logCnt, 32'd4);
    check(sizeBytes == 32'h00200000 && !error, "R10", "result held after run",
          sizeBytes, 32'h00200000);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule